// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Bank

This block holds six independent 32-bit timers behind one small register port. Each channel counts down from a value that software loads, one step per prescaled tick. Its tick comes from one of four tick-enable inputs, all in the same clock domain, and then passes through a divide-by-1-to-8 prescaler. When a channel expires it raises a bit in a shared pending register. A shared enable register then gates that bit onto one interrupt line.

A channel runs periodically when auto-reload is on: it reloads from its interval register at every expiry. In single-shot mode the start bit clears itself at expiry. With neither, the channel parks at zero. Software can write the current value directly, which sets a first expiry that differs from the interval. Clearing the start bit freezes the count, and setting it again resumes from the frozen value. Reads return one cycle after the request, and the interrupt line is registered.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset all registers read zero and irq_o is low.
- R2: Register map (byte offsets): interrupt enable 0x00, pending 0x04. Channel c has its control word at 0x10+0x10*c, its interval at 0x14+0x10*c and its current value at 0x18+0x10*c. Control reads back its low 8 bits with the upper bits zero. A read appears on rd_data in the cycle after rd_en and holds until the next read.
- R3: Control bit 0 (start) set makes the current value drop by one on each prescaled tick. Clearing it freezes the value, and setting it again resumes from that value.
- R4: Control bits 3:2 pick tick input src_tick[n] for n = 0..3. Control bits 6:4 hold the division ratio minus one. The prescaler restarts from zero whenever the channel is stopped.
- R5: A prescaled tick that arrives while the current value is 1 or 0 is an expiry, and it sets pending bit c.
- R6: With control bit 1 (auto-reload) set and bit 7 clear, an expiry loads the interval register into the current value and the channel keeps running.
- R7: With control bit 7 (single-shot) set, an expiry leaves the current value at zero and clears the start bit.
- R8: With auto-reload and single-shot both clear, an expiry leaves the value at zero. Every further tick is another expiry.
- R9: Writing pending clears each bit written as 1 and leaves each bit written as 0. An expiry in the same cycle as a clear keeps the bit set.
- R10: irq_o is the registered OR over channels of pending AND enable, one cycle behind the registers.
- R11: A write to a current-value register takes effect over a tick that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Tick enables for the four clock sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read byte address |
| rd_data | output | DW | Read data, one cycle after rd_en |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with the default parameters: six channels, 32-bit counters and an 8-bit address. It drives the four tick inputs with different periods (every cycle, every 2nd, every 5th and every 3rd). Intervals and start values stay small, so expiries, reloads, self-stops and pending races happen within tens of cycles. A behavioural model covers every channel at once, so cross-channel pending and enable interplay and the prescaler restart on stop are compared on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NSRC      = 4;
  localparam int SRC_W     = 2;
  localparam int PRE_W     = 3;
  localparam int CTRL_W    = 8;
  localparam int IEN_OFS   = 'h00;
  localparam int IPEND_OFS = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h10;
  localparam int CTRL_OFS  = 'h0;
  localparam int INTV_OFS  = 'h4;
  localparam int CUR_OFS   = 'h8;

  // packed MSB first: bit7 single, 6:4 pre, 3:2 src, 1 reload, 0 start
  typedef struct packed {
    logic             single;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             start;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic             sel_tick;
  logic             wrap;

  assign sel_tick = src_tick[src_sel];
  assign wrap     = (cnt_q == ratio_m1);
  assign tick     = run && sel_tick && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (sel_tick) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  a_r4_stop_restart: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            intv_we,
  input  logic            cur_we,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src_tick,
  output tmr_ctrl_t       ctrl_o,
  output logic [DW-1:0]   intv_o,
  output logic [DW-1:0]   cur_o,
  output logic            expire_o
);
  tmr_ctrl_t     ctrl_q;
  logic [DW-1:0] intv_q;
  logic [DW-1:0] cur_q;
  logic          tick;
  logic          expire;
  logic          do_reload;

  tmr_prescale u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.start),
    .src_tick (src_tick),
    .src_sel  (ctrl_q.src),
    .ratio_m1 (ctrl_q.pre),
    .tick     (tick)
  );

  assign expire    = tick && (cur_q[DW-1:1] == '0);
  assign do_reload = ctrl_q.reload && !ctrl_q.single;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end else if (expire && ctrl_q.single) begin
      ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intv_q <= '0;
    end else if (intv_we) begin
      intv_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else if (cur_we) begin
      cur_q <= wdata;
    end else if (expire) begin
      cur_q <= do_reload ? intv_q : '0;
    end else if (tick) begin
      cur_q <= cur_q - 1'b1;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign intv_o   = intv_q;
  assign cur_o    = cur_q;
  assign expire_o = expire;

  a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.start && !cur_we) |=> $stable(cur_q));
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (expire && do_reload && !cur_we) |=> (cur_q == $past(intv_q)));
  a_r7_self_stop: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.single && !ctrl_we) |=> !ctrl_q.start);
  a_r11_sw_wins: assert property (@(posedge clk) disable iff (rst)
    cur_we |=> (cur_q == $past(wdata)));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_we,
  input  logic           pend_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] clr;
  logic           irq_q;

  assign clr = pend_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (en_we) en_q <= wdata;
      pend_q <= (pend_q & ~clr) | expire;
      irq_q  <= |(pend_q & en_q);
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  a_r9_hold_unless_cleared: assert property (@(posedge clk) disable iff (rst)
    !pend_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  a_r5_expire_sets: assert property (@(posedge clk) disable iff (rst)
    (|expire) |=> ((pend_q & $past(expire)) == $past(expire)));
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (irq_o == $past(|(pend_q & en_q))));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_IEN   = AW'(IEN_OFS);
  localparam logic [AW-1:0] A_IPEND = AW'(IPEND_OFS);

  tmr_ctrl_t      ctrl_q [NCH];
  logic [DW-1:0]  intv_q [NCH];
  logic [DW-1:0]  cur_q  [NCH];
  logic [NCH-1:0] expire;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pend_q;
  logic [DW-1:0]  rd_next;
  logic [DW-1:0]  rd_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_CTRL = AW'(CH_BASE + CH_STRIDE*c + CTRL_OFS);
    localparam logic [AW-1:0] A_INTV = AW'(CH_BASE + CH_STRIDE*c + INTV_OFS);
    localparam logic [AW-1:0] A_CUR  = AW'(CH_BASE + CH_STRIDE*c + CUR_OFS);

    tmr_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctrl_we  (wr_en && (wr_addr == A_CTRL)),
      .intv_we  (wr_en && (wr_addr == A_INTV)),
      .cur_we   (wr_en && (wr_addr == A_CUR)),
      .wdata    (wr_data),
      .src_tick (src_tick),
      .ctrl_o   (ctrl_q[c]),
      .intv_o   (intv_q[c]),
      .cur_o    (cur_q[c]),
      .expire_o (expire[c])
    );
  end

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .en_we   (wr_en && (wr_addr == A_IEN)),
    .pend_we (wr_en && (wr_addr == A_IPEND)),
    .wdata   (wr_data[NCH-1:0]),
    .expire  (expire),
    .en_o    (en_q),
    .pend_o  (pend_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (rd_addr == A_IEN)   rd_next = {{(DW-NCH){1'b0}}, en_q};
    if (rd_addr == A_IPEND) rd_next = {{(DW-NCH){1'b0}}, pend_q};
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*c + CTRL_OFS))
        rd_next = {{(DW-CTRL_W){1'b0}}, ctrl_q[c]};
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*c + INTV_OFS))
        rd_next = intv_q[c];
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*c + CUR_OFS))
        rd_next = cur_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

  a_r2_read_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int NCH = 6;
  localparam int DW  = 32;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    src_tick = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  tmr_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_tmr_bank (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_intv [NCH];
  logic [31:0] m_cur  [NCH];
  int          m_pc   [NCH];
  logic [NCH-1:0] m_en, m_pend;
  logic        m_irq;
  logic [31:0] m_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_ctrl[i] = '0; m_intv[i] = '0; m_cur[i] = '0; m_pc[i] = 0;
      end
      m_en = '0; m_pend = '0; m_irq = 1'b0; m_rd = '0;
    end else begin
      logic [NCH-1:0] hits;
      logic [31:0] r;
      hits = '0;
      if (rd_en) begin
        r = '0;
        if (rd_addr == 8'h00) r = 32'(m_en);
        if (rd_addr == 8'h04) r = 32'(m_pend);
        for (int i = 0; i < NCH; i++) begin
          if (int'(rd_addr) == 16 + 16*i) r = 32'(m_ctrl[i]);
          if (int'(rd_addr) == 20 + 16*i) r = m_intv[i];
          if (int'(rd_addr) == 24 + 16*i) r = m_cur[i];
        end
        m_rd = r;
      end
      m_irq = |(m_pend & m_en);
      for (int i = 0; i < NCH; i++) begin
        bit run, s, tk;
        int pre;
        run = m_ctrl[i][0];
        s   = src_tick[m_ctrl[i][3:2]];
        pre = int'(m_ctrl[i][6:4]);
        tk  = run && s && (m_pc[i] == pre);
        if (!run) m_pc[i] = 0;
        else if (s) m_pc[i] = (m_pc[i] == pre) ? 0 : m_pc[i] + 1;
        if (tk) begin
          if (m_cur[i] <= 1) begin
            hits[i] = 1'b1;
            m_cur[i] = (m_ctrl[i][1] && !m_ctrl[i][7]) ? m_intv[i] : 32'd0;
            if (m_ctrl[i][7]) m_ctrl[i][0] = 1'b0;
          end else begin
            m_cur[i] = m_cur[i] - 1;
          end
        end
        if (wr_en) begin
          if (int'(wr_addr) == 16 + 16*i) m_ctrl[i] = wr_data[7:0];
          if (int'(wr_addr) == 20 + 16*i) m_intv[i] = wr_data;
          if (int'(wr_addr) == 24 + 16*i) m_cur[i] = wr_data;
        end
      end
      if (wr_en && wr_addr == 8'h04) m_pend = m_pend & ~wr_data[NCH-1:0];
      m_pend = m_pend | hits;
      if (wr_en && wr_addr == 8'h00) m_en = wr_data[NCH-1:0];
    end
  end

  // tick sources and per-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 irq_o vs model", 32'(irq_o), 32'(m_irq));
      chk("R2 rd_data vs model", rd_data, m_rd);
    end
    src_tick[0] <= 1'b1;
    src_tick[1] <= (cyc % 2 == 0);
    src_tick[2] <= (cyc % 5 == 0);
    src_tick[3] <= (cyc % 3 == 0);
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      finish_up();
    end
  end

  initial begin
    logic [31:0] v, a, b;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 enable reset", v, 0);
    rd(8'h04, v); chk("R1 pending reset", v, 0);
    rd(8'h10, v); chk("R1 ctrl0 reset", v, 0);
    rd(8'h68, v); chk("R1 cur5 reset", v, 0);
    chk("R1 irq reset", 32'(irq_o), 0);

    // R2 map and readback
    wr(8'h34, 32'hDEADBEEF);
    rd(8'h34, v); chk("R2 interval ch2", v, 32'hDEADBEEF);
    wr(8'h30, 32'hFFFFFF5A);
    rd(8'h30, v); chk("R2 ctrl ch2 low byte only", v, 32'h5A);
    wr(8'h30, 0);

    // R6 periodic channel 0, R5 expiry, R10 interrupt
    wr(8'h14, 4); wr(8'h18, 4); wr(8'h00, 1); wr(8'h10, 32'h03);
    idle(20);
    rd(8'h04, v); chk("R5 pending bit0 after expiry", v & 1, 1);
    rd(8'h18, v); chk("R6 reloaded value within interval", 32'(v >= 1 && v <= 4), 1);
    chk("R10 irq with enable", 32'(irq_o), 1);

    // R3 freeze / resume
    wr(8'h10, 32'h02);
    idle(2);
    rd(8'h18, a); idle(5); rd(8'h18, b);
    chk("R3 frozen while stopped", b, a);

    // R9 write-one-to-clear
    wr(8'h04, 0);
    rd(8'h04, v); chk("R9 write zero keeps pending", v & 1, 1);
    wr(8'h04, 1);
    rd(8'h04, v); chk("R9 write one clears", v, 0);
    idle(2);
    chk("R10 irq low after clear", 32'(irq_o), 0);

    wr(8'h18, 30); wr(8'h10, 32'h03);
    idle(3);
    rd(8'h18, v); chk("R3 resumes counting", 32'(v < 30), 1);
    wr(8'h10, 32'h02);
    wr(8'h04, 32'h3F);

    // R7 single-shot on channel 1, source 1, ratio 2
    wr(8'h28, 3); wr(8'h20, 32'h95);
    idle(40);
    rd(8'h20, v); chk("R7 start self-cleared", v, 32'h94);
    rd(8'h28, v); chk("R7 current held at zero", v, 0);
    rd(8'h04, v); chk("R5 pending bit1", (v >> 1) & 1, 1);

    // R8 continuous without reload on channel 3, source 3
    wr(8'h48, 2); wr(8'h40, 32'h0D);
    idle(20);
    rd(8'h04, v); chk("R8 pending bit3", (v >> 3) & 1, 1);
    wr(8'h04, 32'h08);
    idle(10);
    rd(8'h04, v); chk("R8 re-expires at zero", (v >> 3) & 1, 1);
    rd(8'h48, v); chk("R8 parked at zero", v, 0);
    wr(8'h40, 0); wr(8'h04, 32'h3F);

    // R4 prescale divide by 8 on channel 4; source 2 on channel 5
    wr(8'h58, 100); wr(8'h50, 32'h71);
    wr(8'h68, 50);  wr(8'h60, 32'h09);
    idle(80);
    wr(8'h50, 0); wr(8'h60, 0);
    rd(8'h58, v); chk("R4 divide by 8 count", 32'(v >= 88 && v <= 92), 1);
    rd(8'h68, v); chk("R4 source 2 count", 32'(v >= 32 && v <= 36), 1);

    // R9 set wins over clear, channel 0 expiring every tick
    wr(8'h14, 1); wr(8'h18, 1); wr(8'h10, 32'h03);
    idle(3);
    wr(8'h04, 1);
    rd(8'h04, v); chk("R9 expiry beats clear", v & 1, 1);

    // R11 software write beats tick
    wr(8'h14, 60);
    wr(8'h18, 50);
    rd(8'h18, v); chk("R11 written value lands", v, 50);
    wr(8'h10, 32'h02);

    // R10 enable gating
    wr(8'h00, 0);
    idle(2);
    chk("R10 masked irq", 32'(irq_o), 0);
    wr(8'h00, 1);
    idle(2);
    chk("R10 unmasked irq", 32'(irq_o), 1);

    idle(5);
    finish_up();
  end
endmodule